// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block decides which operating mode a CAN controller is in: sleep (clocks gated, lowest power), initial (configuration, with the protocol engine held off the bus) or normal (taking part in bus traffic). Software drives two level request bits, a sleep request and an initial request. The block combines them with an auto-wake enable, the receive line, a bit-time tick and a frame-busy flag from the protocol engine. From these it produces the current mode, two status flags, a clock-enable for the protocol engine, and a one-clock wake-up event.

While asleep, a dominant level on the receive line can end sleep without software help, if auto-wake is enabled. In that case the block also returns a one-clock strobe that clears the software sleep request bit. Moving from initial to normal waits until the bus has been idle for a run of recessive bit samples. Mode requests that arrive from normal mode wait until the current frame has finished.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the mode is sleep (mode code 2'b00), sleepSts is 1, initSts is 0 and protoClkEn is 0. protoClkEn is 0 in every cycle spent in sleep and 1 in every other cycle.
- R2: From initial mode, or from normal mode while frameBusy is low, an active sleep request moves the block to sleep on the next clock edge, and sleepSts goes high at the same edge.
- R3: In sleep with no auto-wake, a low sleepReq moves the block on the next edge. It goes to initial mode (code 2'b01) if initReq is 1, and to normal mode (code 2'b10) if initReq is 0.
- R4: In sleep, while sleepReq stays 1, the mode stays sleep unless autoWakeEn is 1 and rxIn is low. A low rxIn has no effect when autoWakeEn is 0.
- R5: rxIn passes through a two-flop synchronizer. With autoWakeEn at 1 in sleep, rxIn going low at a falling edge changes the mode on the third rising edge after it. The new mode is initial if initReq is 1 and normal otherwise.
- R6: On an auto-wake, wakeEvt and sleepReqClr are each high for exactly one cycle, in the first cycle of the new mode. A sleepReq that is still held at 1 is then ignored until software drives it to 0.
- R7: Initial mode goes to normal only when initReq and sleepReq are both 0 and 11 consecutive bitTick samples of the synchronized line have been recessive. A dominant sample on a tick restarts the count. The change happens on the edge after the eleventh tick.
- R8: In normal mode, while frameBusy is 1, neither request changes the mode. A pending request takes effect at the first rising edge at which frameBusy is low.
- R9: In normal mode with frameBusy low and both requests set, the block goes to initial mode, not sleep.
- R10: initSts is 1 exactly while the mode is initial. sleepSts and initSts are never 1 together, and mode never takes the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Software sleep request level |
| initReq | input | 1 | Software initial-mode request level |
| autoWakeEn | input | 1 | Allows bus activity to end sleep |
| rxIn | input | 1 | Raw receive line, low is dominant |
| bitTick | input | 1 | One-cycle strobe at each bit sample point |
| frameBusy | input | 1 | Protocol engine is inside a frame |
| mode | output | 2 | Current mode: 00 sleep, 01 initial, 10 normal |
| sleepStat | output | 1 | High while in sleep |
| initStat | output | 1 | High while in initial mode |
| protoClkEn | output | 1 | Clock enable for the protocol engine |
| wakeEvt | output | 1 | One-cycle pulse on auto-wake |
| sleepReqClr | output | 1 | One-cycle strobe to clear the sleep request bit |

## Verification
The checker tests on every cycle the properties that hold at all times. The status flags are mutually exclusive and the mode code is never illegal. The clock-enable follows the mode. The wake pulse lasts one cycle and coincides with leaving sleep. The mode holds while a frame is busy or while the sleep request stays set without a wake. A request pending in normal mode resolves to initial mode first.

Some behaviours can only be shown by the bench's scenarios. These are the exact three-edge delay through the synchronizer, and the count of eleven idle ticks together with its restart on a dominant sample. Others are the masking of a sleep request that is still held after an auto-wake, and the full sweep of every request, wake-enable and line combination from sleep.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'b00,
    MODE_INIT   = 2'b01,
    MODE_NORMAL = 2'b10
  } canMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wakeHit;   // auto-wake taken this cycle
    logic cntClr;    // hold idle counter at zero
  } ctrlStrb_t;

endpackage

// File: rtl/can_mode_dp.sv
module can_mode_dp
  import can_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_BITS   = 11,
  localparam int CNT_W      = $clog2(IDLE_BITS + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxIn,
  input  logic      bitTick,
  input  logic      sleepReq,
  input  ctrlStrb_t strb,
  output logic      rxSync,
  output logic      idleDone,
  output logic      effSleep,
  output logic      wakeEvt,
  output logic      sleepReqClr
);

  // receive line synchronizer, reset to recessive
  logic [SYNC_STAGES-1:0] syncChain;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b1;
          else       syncChain[0] <= rxIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[g] <= 1'b1;
          else       syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  assign rxSync = syncChain[SYNC_STAGES-1];

  // consecutive recessive bit counter, saturating
  logic [CNT_W-1:0] idleCnt;
  localparam logic [CNT_W-1:0] IDLE_MAX = CNT_W'(IDLE_BITS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strb.cntClr) begin
      idleCnt <= '0;
    end else if (bitTick) begin
      if (!rxSync)                idleCnt <= '0;
      else if (idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
    end
  end

  assign idleDone = (idleCnt == IDLE_MAX);

  // sleep request mask after hardware wake
  logic wakeMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeMask    <= 1'b0;
      wakeEvt     <= 1'b0;
      sleepReqClr <= 1'b0;
    end else begin
      wakeEvt     <= strb.wakeHit;
      sleepReqClr <= strb.wakeHit;
      if (strb.wakeHit)  wakeMask <= 1'b1;
      else if (!sleepReq) wakeMask <= 1'b0;
    end
  end

  assign effSleep = sleepReq && !wakeMask;

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      initReq,
  input  logic      autoWakeEn,
  input  logic      frameBusy,
  input  logic      rxSync,
  input  logic      idleDone,
  input  logic      effSleep,
  output canMode_e  curMode,
  output ctrlStrb_t strb
);

  canMode_e nxtMode;
  logic     wakeHit;
  canMode_e wakeTarget;

  assign wakeTarget = initReq ? MODE_INIT : MODE_NORMAL;

  always_comb begin
    nxtMode = curMode;
    wakeHit = 1'b0;
    unique case (curMode)
      MODE_SLEEP: begin
        if (autoWakeEn && !rxSync) begin
          wakeHit = 1'b1;
          nxtMode = wakeTarget;
        end else if (!effSleep) begin
          nxtMode = wakeTarget;
        end
      end
      MODE_INIT: begin
        if (effSleep)                 nxtMode = MODE_SLEEP;
        else if (!initReq && idleDone) nxtMode = MODE_NORMAL;
      end
      MODE_NORMAL: begin
        if (!frameBusy) begin
          if (initReq)       nxtMode = MODE_INIT;
          else if (effSleep) nxtMode = MODE_SLEEP;
        end
      end
      default: nxtMode = MODE_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curMode <= MODE_SLEEP;
    else       curMode <= nxtMode;
  end

  always_comb begin
    strb.wakeHit = wakeHit;
    strb.cntClr  = (curMode != MODE_INIT);
  end

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_BITS   = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       initReq,
  input  logic       autoWakeEn,
  input  logic       rxIn,
  input  logic       bitTick,
  input  logic       frameBusy,
  output logic [1:0] mode,
  output logic       sleepStat,
  output logic       initStat,
  output logic       protoClkEn,
  output logic       wakeEvt,
  output logic       sleepReqClr
);

  canMode_e  curMode;
  ctrlStrb_t strb;
  logic      rxSync;
  logic      idleDone;
  logic      effSleep;

  can_mode_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .initReq    (initReq),
    .autoWakeEn (autoWakeEn),
    .frameBusy  (frameBusy),
    .rxSync     (rxSync),
    .idleDone   (idleDone),
    .effSleep   (effSleep),
    .curMode    (curMode),
    .strb       (strb)
  );

  can_mode_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .IDLE_BITS   (IDLE_BITS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .rxIn        (rxIn),
    .bitTick     (bitTick),
    .sleepReq    (sleepReq),
    .strb        (strb),
    .rxSync      (rxSync),
    .idleDone    (idleDone),
    .effSleep    (effSleep),
    .wakeEvt     (wakeEvt),
    .sleepReqClr (sleepReqClr)
  );

  assign mode       = curMode;
  assign sleepStat  = (curMode == MODE_SLEEP);
  assign initStat   = (curMode == MODE_INIT);
  assign protoClkEn = (curMode != MODE_SLEEP);

endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sleepReq,
  input logic       initReq,
  input logic       autoWakeEn,
  input logic       frameBusy,
  input logic [1:0] mode,
  input logic       sleepStat,
  input logic       initStat,
  input logic       protoClkEn,
  input logic       wakeEvt,
  input logic       sleepReqClr
);

  // R1
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoClkEn == !sleepStat);

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sleepStat && initStat) && (mode != 2'b11));

  // R10
  init_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    initStat == (mode == 2'b01));

  // R6
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvt |=> !wakeEvt);

  // R6
  wake_leave_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvt |-> (!sleepStat && sleepReqClr));

  // R4
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepStat && sleepReq && !autoWakeEn) |=> sleepStat);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 && frameBusy) |=> mode == 2'b10);

  // R9
  init_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 && !frameBusy && initReq) |=> initStat);

  // R7
  init_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (initStat && initReq && !sleepReq) |=> initStat);

endmodule

bind can_mode_seq can_mode_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sleepReq    (sleepReq),
  .initReq     (initReq),
  .autoWakeEn  (autoWakeEn),
  .frameBusy   (frameBusy),
  .mode        (mode),
  .sleepStat   (sleepStat),
  .initStat    (initStat),
  .protoClkEn  (protoClkEn),
  .wakeEvt     (wakeEvt),
  .sleepReqClr (sleepReqClr)
);

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] M_SLEEP  = 2'b00;
  localparam logic [1:0] M_INIT   = 2'b01;
  localparam logic [1:0] M_NORMAL = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b1, initReq = 1'b0, autoWakeEn = 1'b0;
  logic rxIn = 1'b1, bitTick = 1'b0, frameBusy = 1'b0;
  logic [1:0] mode;
  logic sleepStat, initStat, protoClkEn, wakeEvt, sleepReqClr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mode_seq dut (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .initReq(initReq),
    .autoWakeEn(autoWakeEn), .rxIn(rxIn), .bitTick(bitTick),
    .frameBusy(frameBusy), .mode(mode), .sleepStat(sleepStat),
    .initStat(initStat), .protoClkEn(protoClkEn), .wakeEvt(wakeEvt),
    .sleepReqClr(sleepReqClr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chkMode(input logic [1:0] exp, input string tag);
    check(mode == exp, tag, int'(mode), int'(exp));
    check(sleepStat == (exp == M_SLEEP) && initStat == (exp == M_INIT)
          && protoClkEn == (exp != M_SLEEP), {tag, " flags R10"},
          int'({sleepStat, initStat, protoClkEn}), int'(exp));
  endtask

  task automatic goSleep();
    sleepReq = 1'b0; initReq = 1'b0; autoWakeEn = 1'b0;
    rxIn = 1'b1; frameBusy = 1'b0; bitTick = 1'b0;
    step(1);
    sleepReq = 1'b1;
    step(4);
  endtask

  task automatic goInit();
    goSleep();
    initReq = 1'b1; sleepReq = 1'b0;
    step(1);
  endtask

  task automatic pulseTick();
    bitTick = 1'b1;
    step(1);
    bitTick = 1'b0;
    step(1);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chkMode(M_SLEEP, "R1 in reset");
    rstN = 1'b1;
    step(2);
    chkMode(M_SLEEP, "R1 after reset");
    check(wakeEvt == 1'b0, "R1 no wake", int'(wakeEvt), 0);

    // R3 R4 R5 R6 sweep over all exits from sleep
    for (int c = 0; c < 16; c++) begin
      logic i, s, a, r, wk;
      logic [1:0] exp;
      i = c[0]; s = c[1]; a = c[2]; r = c[3];
      goSleep();
      initReq = i; sleepReq = s; autoWakeEn = a; rxIn = r;
      wk = s && a && !r;
      exp = (!s || wk) ? (i ? M_INIT : M_NORMAL) : M_SLEEP;
      step(2);
      if (wk) chkMode(M_SLEEP, "R5 sync delay");
      step(1);
      chkMode(exp, $sformatf("R3/R4/R5 sweep c=%0d", c));
      check(wakeEvt == wk && sleepReqClr == wk, "R6 pulse",
            int'({wakeEvt, sleepReqClr}), wk ? 3 : 0);
      step(1);
      check(wakeEvt == 1'b0 && sleepReqClr == 1'b0, "R6 pulse end",
            int'({wakeEvt, sleepReqClr}), 0);
      step(3);
      chkMode(exp, "R6 held request masked");
    end

    // R2 sleep from init
    goInit();
    chkMode(M_INIT, "R3 to init");
    sleepReq = 1'b1;
    step(1);
    chkMode(M_SLEEP, "R2 init to sleep");

    // R7 idle run of eleven ticks
    goInit();
    initReq = 1'b0;
    for (int t = 0; t < 10; t++) pulseTick();
    chkMode(M_INIT, "R7 ten ticks");
    pulseTick();
    chkMode(M_NORMAL, "R7 eleventh tick");

    // R7 dominant sample restarts
    goInit();
    initReq = 1'b0;
    for (int t = 0; t < 6; t++) pulseTick();
    rxIn = 1'b0;
    step(3);
    pulseTick();
    rxIn = 1'b1;
    step(3);
    for (int t = 0; t < 10; t++) pulseTick();
    chkMode(M_INIT, "R7 restart ten");
    pulseTick();
    chkMode(M_NORMAL, "R7 restart eleven");

    // R2 sleep from normal
    sleepReq = 1'b1;
    step(1);
    chkMode(M_SLEEP, "R2 normal to sleep");

    // R8 deferral of init request
    goSleep();
    sleepReq = 1'b0;
    step(1);
    chkMode(M_NORMAL, "R3 to normal");
    frameBusy = 1'b1; initReq = 1'b1;
    step(5);
    chkMode(M_NORMAL, "R8 held while busy");
    frameBusy = 1'b0;
    step(1);
    chkMode(M_INIT, "R8 after busy");

    // R8 deferral of sleep request
    goSleep();
    sleepReq = 1'b0;
    step(1);
    frameBusy = 1'b1; sleepReq = 1'b1;
    step(4);
    chkMode(M_NORMAL, "R8 sleep held");
    frameBusy = 1'b0;
    step(1);
    chkMode(M_SLEEP, "R8 sleep after busy");

    // R9 priority
    goSleep();
    sleepReq = 1'b0;
    step(1);
    sleepReq = 1'b1; initReq = 1'b1;
    step(1);
    chkMode(M_INIT, "R9 init wins");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule